// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small bank of system control registers on a simple synchronous register bus. A write is taken on the rising clock edge when `bus_wr` is high. `bus_rdata` is a combinational view of the register that `bus_addr` selects. The bank holds:

- byte-wide storage for configuration, diagnostics and modem control;
- a 16-bit LED register;
- two auxiliary registers whose bits have side effects;
- a system-control register that records that a reset command was issued.

The block drives a power-fail interrupt. It also issues one-cycle strobes to outside logic: a terminal-count strobe, a power-off request and a system-reset request.

The power-fail status is held by a two-state machine with the states `PF_CLEAR` and `PF_RAISED`. The machine moves only on two kinds of event:

- **Transition T_EDGE** runs on any change of the `pwr_failing` level. It enters `PF_RAISED` if the new level is high and the interrupt enable is set. In every other case it enters `PF_CLEAR`.
- **Transition T_ACK** runs on an auxiliary-2 write with bit 1 (acknowledge) set. It enters `PF_CLEAR`.

In every other cycle the machine holds its state. It has two resets:

- A power-on reset (`por_n`) clears everything.
- The block reset (`rst_n`) clears only the configuration, modem, auxiliary-1 and auxiliary-2 state. The diagnostic, LED and system-control registers keep their values across it.

Top module: `sysaux_regs`

## Requirements
- R1: Offsets 0 (configuration), 1 (diagnostic) and 2 (modem) are 8-bit read/write registers. Offset 3 (LED) is a 16-bit read/write register. Reads are zero-extended to 32 bits.
- R2: Offsets 7 to 15 read as zero. Writes to them change no register and fire no strobe.
- R3: A write to offset 5 (auxiliary-1) stores the low byte with bit 1 forced to zero. If bit 1 of the write is set, `tc_strobe` is high in the cycle after the write.
- R4: A write to offset 6 (auxiliary-2) stores only bit 0 (power-off) from the data. Bit 1 never reads back, and the other written bits read as zero. Bit 5 (power-fail status) is kept from before the write.
- R5: An auxiliary-2 write with bit 0 set drives `pwroff_req` high in the cycle after the write.
- R6: On each change of `pwr_failing`, auxiliary-2 bit 5 becomes the new level ANDed with configuration bit 3. Bit 5 does not change while the input is steady.
- R7: An auxiliary-2 write with bit 1 set clears auxiliary-2 bit 5.
- R8: `pwr_irq` is high exactly when auxiliary-2 bit 5 and configuration bit 3 are both set. A configuration write changes the interrupt but not bit 5.
- R9: A write to offset 4 (system control) with bit 0 set makes the register read 0x00000002 and drives `sysrst_req` high in the next cycle. A write with bit 0 clear has no effect. All other bits read as zero.
- R10: A low on `rst_n` clears configuration, modem, auxiliary-1 and auxiliary-2 (including bit 5). It leaves diagnostic, LED and system control unchanged.
- R11: A low on `por_n` clears every register and every output.
- R12: If a `pwr_failing` change and an acknowledge write land in the same cycle, the input change decides bit 5.
- R13: `tc_strobe`, `pwroff_req` and `sysrst_req` are single-cycle pulses for a single-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears all |
| rst_n | input | 1 | Block reset, asynchronous, active low, partial clear |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| pwr_failing | input | 1 | Power-failing level from the supply monitor |
| pwr_irq | output | 1 | Power-fail interrupt |
| tc_strobe | output | 1 | One-cycle terminal-count strobe |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system-reset request |

## Verification
Two functions can land in the same clock cycle: a change of the `pwr_failing` level (T_EDGE) and an acknowledge write to auxiliary-2 (T_ACK). Both act on the power-fail status bit. The bench drives the new input level and the acknowledging write on the same falling edge. It then expects auxiliary-2 to read 0x20 and `pwr_irq` to be high, because the input change wins. A second case with a steady input checks that the same write alone clears the bit.

// File: rtl/sysaux_pkg.sv
package sysaux_pkg;
    localparam int BYTE_W  = 8;
    localparam int LED_W   = 16;
    localparam int REG_CNT = 7;

    localparam int REG_CFG  = 0;
    localparam int REG_DIAG = 1;
    localparam int REG_MDM  = 2;
    localparam int REG_LED  = 3;
    localparam int REG_SYSC = 4;
    localparam int REG_AUX1 = 5;
    localparam int REG_AUX2 = 6;

    localparam int CFG_PIE_BIT  = 3;
    localparam int AUX1_TC_BIT  = 1;
    localparam int AUX2_OFF_BIT = 0;
    localparam int AUX2_ACK_BIT = 1;
    localparam int AUX2_PF_BIT  = 5;
    localparam int SYSC_CMD_BIT = 0;
    localparam int SYSC_STS_BIT = 1;

    localparam int STB_CNT  = 3;
    localparam int STB_TC   = 0;
    localparam int STB_OFF  = 1;
    localparam int STB_RST  = 2;

    typedef enum logic {
        PF_CLEAR  = 1'b0,
        PF_RAISED = 1'b1
    } pf_state_e;
endpackage

// File: rtl/sysaux_decode.sv
module sysaux_decode
    import sysaux_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [REG_CNT-1:0] sel
);
    for (genvar i = 0; i < REG_CNT; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/sysaux_pf_fsm.sv
module sysaux_pf_fsm
    import sysaux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic en,
    input  logic ack,
    output logic pf
);
    pf_state_e state_q, state_d;
    logic      lvl_q;
    logic      edge_seen;

    assign edge_seen = (lvl != lvl_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_CLEAR: begin
                if (edge_seen && lvl && en) state_d = PF_RAISED;
            end
            PF_RAISED: begin
                if (edge_seen)      state_d = (lvl && en) ? PF_RAISED : PF_CLEAR;
                else if (ack)       state_d = PF_CLEAR;
            end
            default: state_d = PF_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PF_CLEAR;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl;
        end
    end

    always_comb begin
        pf = (state_q == PF_RAISED);
    end
endmodule

// File: rtl/sysaux_strobe.sv
module sysaux_strobe #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_stb
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= fire[i];
        end
    end
endmodule

// File: rtl/sysaux_regs.sv
module sysaux_regs
    import sysaux_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pwr_failing,
    output logic              pwr_irq,
    output logic              tc_strobe,
    output logic              pwroff_req,
    output logic              sysrst_req
);
    logic [REG_CNT-1:0] sel;
    logic [REG_CNT-1:0] we;
    logic               soft_n;
    logic [BYTE_W-1:0]  cfg_q, diag_q, mdm_q, aux1_q;
    logic [LED_W-1:0]   led_q;
    logic               off_q;
    logic               rst_seen_q;
    logic               pf;
    logic [STB_CNT-1:0] fire, pulse;
    logic [DATA_W-LED_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = bus_wdata[DATA_W-1:LED_W];
    assign soft_n = por_n & rst_n;
    assign we     = sel & {REG_CNT{bus_wr}};

    sysaux_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_ff @(posedge clk or negedge soft_n) begin
        if (!soft_n) begin
            cfg_q  <= '0;
            mdm_q  <= '0;
            aux1_q <= '0;
            off_q  <= 1'b0;
        end else begin
            if (we[REG_CFG])  cfg_q  <= bus_wdata[BYTE_W-1:0];
            if (we[REG_MDM])  mdm_q  <= bus_wdata[BYTE_W-1:0];
            if (we[REG_AUX1]) begin
                aux1_q              <= bus_wdata[BYTE_W-1:0];
                aux1_q[AUX1_TC_BIT] <= 1'b0;
            end
            if (we[REG_AUX2]) off_q <= bus_wdata[AUX2_OFF_BIT];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            diag_q     <= '0;
            led_q      <= '0;
            rst_seen_q <= 1'b0;
        end else begin
            if (we[REG_DIAG]) diag_q <= bus_wdata[BYTE_W-1:0];
            if (we[REG_LED])  led_q  <= bus_wdata[LED_W-1:0];
            if (we[REG_SYSC] && bus_wdata[SYSC_CMD_BIT]) rst_seen_q <= 1'b1;
        end
    end

    sysaux_pf_fsm u_pf (
        .clk   (clk),
        .rst_n (soft_n),
        .lvl   (pwr_failing),
        .en    (cfg_q[CFG_PIE_BIT]),
        .ack   (we[REG_AUX2] && bus_wdata[AUX2_ACK_BIT]),
        .pf    (pf)
    );

    assign pwr_irq = pf && cfg_q[CFG_PIE_BIT];

    assign fire[STB_TC]  = we[REG_AUX1] && bus_wdata[AUX1_TC_BIT];
    assign fire[STB_OFF] = we[REG_AUX2] && bus_wdata[AUX2_OFF_BIT];
    assign fire[STB_RST] = we[REG_SYSC] && bus_wdata[SYSC_CMD_BIT];

    sysaux_strobe #(.N(STB_CNT)) u_stb (
        .clk   (clk),
        .rst_n (soft_n),
        .fire  (fire),
        .pulse (pulse)
    );

    assign tc_strobe  = pulse[STB_TC];
    assign pwroff_req = pulse[STB_OFF];
    assign sysrst_req = pulse[STB_RST];

    always_comb begin
        bus_rdata = '0;
        if (sel[REG_CFG])  bus_rdata[BYTE_W-1:0] = cfg_q;
        if (sel[REG_DIAG]) bus_rdata[BYTE_W-1:0] = diag_q;
        if (sel[REG_MDM])  bus_rdata[BYTE_W-1:0] = mdm_q;
        if (sel[REG_LED])  bus_rdata[LED_W-1:0]  = led_q;
        if (sel[REG_SYSC]) bus_rdata[SYSC_STS_BIT] = rst_seen_q;
        if (sel[REG_AUX1]) bus_rdata[BYTE_W-1:0] = aux1_q;
        if (sel[REG_AUX2]) begin
            bus_rdata[AUX2_OFF_BIT] = off_q;
            bus_rdata[AUX2_PF_BIT]  = pf;
        end
    end
endmodule

// File: rtl/sysaux_regs_chk.sv
module sysaux_regs_chk
    import sysaux_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wd_b0,
    input logic              wd_b1,
    input logic              pwr_failing,
    input logic              cfg_en,
    input logic              pwr_irq,
    input logic              tc_strobe,
    input logic              pwroff_req,
    input logic              sysrst_req
);
    logic prev_in;
    logic wr_aux1, wr_aux2, wr_sysc, wr_cfg, in_chg;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) prev_in <= 1'b0;
        else if (!rst_n) prev_in <= 1'b0;
        else prev_in <= pwr_failing;
    end

    assign wr_aux1 = bus_wr && (bus_addr == ADDR_W'(REG_AUX1));
    assign wr_aux2 = bus_wr && (bus_addr == ADDR_W'(REG_AUX2));
    assign wr_sysc = bus_wr && (bus_addr == ADDR_W'(REG_SYSC));
    assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
    assign in_chg  = (pwr_failing != prev_in);

    // R3
    tc_fire_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_aux1 && wd_b1) |=> tc_strobe);

    // R13
    tc_width_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (tc_strobe && !(wr_aux1 && wd_b1)) |=> !tc_strobe);

    // R5
    pwroff_fire_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_aux2 && wd_b0) |=> pwroff_req);

    // R9
    sysrst_only_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        !(wr_sysc && wd_b0) |=> !sysrst_req);

    // R6
    pf_raise_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (in_chg && pwr_failing && cfg_en && !wr_cfg) |=> pwr_irq);

    // R7
    pf_ack_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (wr_aux2 && wd_b1 && !in_chg) |=> !pwr_irq);
endmodule

bind sysaux_regs sysaux_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wd_b0       (bus_wdata[0]),
    .wd_b1       (bus_wdata[1]),
    .pwr_failing (pwr_failing),
    .cfg_en      (cfg_q[sysaux_pkg::CFG_PIE_BIT]),
    .pwr_irq     (pwr_irq),
    .tc_strobe   (tc_strobe),
    .pwroff_req  (pwroff_req),
    .sysrst_req  (sysrst_req)
);

// File: tb/sysaux_regs_tb.sv
module sysaux_regs_tb;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwr_failing = 1'b0;
    logic          pwr_irq, tc_strobe, pwroff_req, sysrst_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sysaux_regs #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_failing(pwr_failing), .pwr_irq(pwr_irq), .tc_strobe(tc_strobe),
        .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input int a, input logic [31:0] e);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        chk(req, bus_rdata, e);
    endtask

    task automatic set_pwr(input logic v);
        @(negedge clk);
        pwr_failing = v;
        @(negedge clk);
    endtask

    task automatic strobes(input string req, input logic [2:0] e);
        chk(req, {29'd0, sysrst_req, pwroff_req, tc_strobe}, {29'd0, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        // R11 reset state
        for (int a = 0; a < 16; a++) rd("R11 reset read", a, 32'd0);
        strobes("R11 reset strobes", 3'b000);
        chk("R11 reset irq", {31'd0, pwr_irq}, 32'd0);

        // R1 plain storage
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d;
            d = 32'hC3A5_0000 | (32'(i) * 32'h1D3B) | 32'h1;
            wr(1, d); wr(2, ~d); wr(3, d);
            rd("R1 diag", 1, {24'd0, d[7:0]});
            rd("R1 modem", 2, {24'd0, ~d[7:0]});
            rd("R1 led", 3, {16'd0, d[15:0]});
            wr(0, {d[31:4], 1'b0, d[2:0]});
            rd("R1 cfg", 0, {24'd0, d[7:4], 1'b0, d[2:0]});
        end

        // R3 auxiliary-1 sweep, R13 width
        for (int v = 0; v < 256; v++) begin
            wr(5, 32'hFFFF_FF00 | 32'(v));
            strobes("R3 tc strobe", {2'b00, v[1]});
            @(negedge clk);
            strobes("R13 tc single", 3'b000);
            rd("R3 aux1 read", 5, 32'(v) & 32'hFD);
        end

        // R4 R5 R7 auxiliary-2 sweep with power-fail raised before each write
        wr(0, 32'h08);
        for (int v = 0; v < 256; v++) begin
            set_pwr(1'b0);
            set_pwr(1'b1);
            wr(6, 32'(v));
            strobes("R5 pwroff strobe", {1'b0, v[0], 1'b0});
            chk("R7 irq after aux2 write", {31'd0, pwr_irq}, {31'd0, ~v[1]});
            rd("R4 aux2 read", 6, (v[1] ? 32'd0 : 32'h20) | 32'(v[0]));
            strobes("R13 pwroff single", 3'b000);
        end

        // R6 R8 input edges and configuration gating
        wr(6, 32'h2);
        set_pwr(1'b0);
        rd("R6 falling clears", 6, 32'd0);
        wr(0, 32'h00);
        set_pwr(1'b1);
        rd("R6 disabled edge", 6, 32'd0);
        chk("R8 irq disabled", {31'd0, pwr_irq}, 32'd0);
        wr(0, 32'h08);
        rd("R6 steady input no change", 6, 32'd0);
        set_pwr(1'b0);
        set_pwr(1'b1);
        chk("R8 irq raised", {31'd0, pwr_irq}, 32'd1);
        wr(0, 32'h00);
        chk("R8 cfg masks irq", {31'd0, pwr_irq}, 32'd0);
        rd("R8 bit5 kept", 6, 32'h20);
        wr(0, 32'h08);
        chk("R8 cfg unmasks irq", {31'd0, pwr_irq}, 32'd1);

        // R12 input change and acknowledge in the same cycle
        set_pwr(1'b0);
        @(negedge clk);
        pwr_failing = 1'b1; bus_addr = AW'(6); bus_wdata = 32'h2; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R12 irq edge wins", {31'd0, pwr_irq}, 32'd1);
        rd("R12 aux2 edge wins", 6, 32'h20);

        // R9 system control
        rd("R9 initial", 4, 32'd0);
        wr(4, 32'hFFFF_FFFE);
        strobes("R9 no request", 3'b000);
        rd("R9 bit0 clear ignored", 4, 32'd0);
        wr(4, 32'h1);
        strobes("R9 request", 3'b100);
        @(negedge clk);
        strobes("R13 sysrst single", 3'b000);
        rd("R9 status", 4, 32'h2);

        // R2 unmapped offsets
        wr(1, 32'h5A); wr(2, 32'h3C); wr(3, 32'hBEEF); wr(5, 32'h81);
        for (int a = 7; a < 16; a++) begin
            wr(a, 32'hFFFF_FFFF);
            strobes("R2 no strobe", 3'b000);
            rd("R2 reads zero", a, 32'd0);
        end
        rd("R2 cfg kept", 0, 32'h08);
        rd("R2 diag kept", 1, 32'h5A);
        rd("R2 modem kept", 2, 32'h3C);
        rd("R2 led kept", 3, 32'hBEEF);
        rd("R2 aux1 kept", 5, 32'h81);
        rd("R2 aux2 kept", 6, 32'h20);

        // R10 block reset
        wr(6, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd("R10 cfg cleared", 0, 32'd0);
        rd("R10 diag kept", 1, 32'h5A);
        rd("R10 modem cleared", 2, 32'd0);
        rd("R10 led kept", 3, 32'hBEEF);
        rd("R10 sysc kept", 4, 32'h2);
        rd("R10 aux1 cleared", 5, 32'd0);
        rd("R10 aux2 cleared", 6, 32'd0);
        chk("R10 irq cleared", {31'd0, pwr_irq}, 32'd0);

        // R11 power-on reset
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        pwr_failing = 1'b0;
        for (int a = 0; a < 7; a++) rd("R11 por clears", a, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule